// File: doc/BRIEF.md
# Timed-Unlock Interrupt Vector Selector

This block holds a single select bit that chooses where the interrupt table lives: at a fixed application base or at a parameterized boot base. Software cannot flip the bit with one store. It must first write a register with the change-enable bit at one, and then, within a short window, write the new select value with the change-enable bit at zero. Writes that break this sequence leave the select bit as it was.

While the sequence runs, the block raises an interrupt-block output. It does this without touching any global interrupt-enable flag, because it has no path to one. The output rises with the unlock write and stays high until the instruction after the committing write has retired. If no commit arrives, it drops when the window expires. The same output also applies a lock policy. Two lock inputs can forbid interrupts while code runs from the section that does not hold the vectors.

The core is a three-state machine. IDLE means no sequence is open. ARMED means the window is open, and a down-counter tracks the cycles that remain. HOLD means a commit has been taken and the block is waiting for the next instruction to retire. The transitions are named as follows:
- ARM goes from any state to ARMED on an enable write.
- COMMIT goes from ARMED to HOLD on a select write.
- EXPIRE goes from ARMED to IDLE when the counter runs out.
- RELEASE goes from HOLD to IDLE on a retire pulse.

Top module: `ivs_vector_select`

## Requirements
- R1: After reset the select bit is 0, `vec_base` equals the application base, the read value is 0, and `irq_block` is 0 while both lock inputs are low.
- R2: A write strobe to the register address with data bit 0 (change-enable) at 1 opens the window (ARM). Read bit 0 then reads 1, and the select bit keeps its value whatever data bit 1 carries.
- R3: When the window is open, a write to the register address with data bit 0 at 0 copies data bit 1 into the select bit and closes the window (COMMIT). The write is taken if its strobe edge is 1 to 4 clock edges after the arming edge.
- R4: With no commit, the window closes 4 edges after the arming edge (EXPIRE), and read bit 0 returns to 0. A write with data bit 0 at 0 outside a window leaves the select bit unchanged.
- R5: `irq_block` is 1 in every cycle from the arming edge until the window expires. After a commit it stays 1 until the edge that samples the next `retire` pulse, and it is 0 from then on (RELEASE).
- R6: An enable write while the window is open restarts the full 4-edge window and does not change the select bit.
- R7: With select at 1 (boot base) and `lock_boot` high, `irq_block` is 1 whenever `in_boot` is 0.
- R8: With select at 0 (application base) and `lock_app` high, `irq_block` is 1 whenever `in_boot` is 1.
- R9: `vec_base` equals `APP_BASE` when the select bit is 0 and `BOOT_BASE` when it is 1.
- R10: `rd_data` is combinational. At the register address, bit 1 carries the select bit, bit 0 carries the live change-enable bit, and all other bits are 0. At any other address it is all zeros. Writes to other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data: bit 0 change-enable, bit 1 select |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |
| retire | input | 1 | One-cycle pulse per retired instruction |
| in_boot | input | 1 | Current fetch is in the boot section |
| lock_boot | input | 1 | Boot-side lock: forbids interrupts from application code when vectors are at boot |
| lock_app | input | 1 | Application-side lock: forbids interrupts from boot code when vectors are at application |
| vec_base | output | BASE_W | Interrupt table base address |
| irq_block | output | 1 | Interrupt delivery must be held off |

## Verification
A state machine stuck in ARMED or HOLD shows at once: `irq_block` stays high and read bit 0 stays wrong on the cycle after the expected EXPIRE or RELEASE edge. A counter that is off by one surfaces at the window boundary. A commit timed exactly at the fourth edge, or at the fifth, flips `vec_base` when it should not, or fails to flip it when it should, on the very next cycle. A select bit corrupted by a bad sequence appears in `vec_base` and in read bit 1 immediately after the offending edge. Policy faults show combinationally as soon as the lock and section inputs settle.

// File: rtl/ivs_pkg.sv
`timescale 1ns/1ps
package ivs_pkg;

    // Sequencer states of the vector-select unlock machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no sequence open
        ST_ARMED = 2'd1,   // unlock window open, counting down
        ST_HOLD  = 2'd2    // select committed, waiting for next retire
    } ivs_state_e;

endpackage

// File: rtl/ivs_regif.sv
`timescale 1ns/1ps
// Register decode: turns bus writes into arm/commit requests and builds read data.
module ivs_regif #(
    parameter int              ADDR_W   = 6,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h35,
    parameter int              CE_POS   = 0,
    parameter int              SEL_POS  = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sel,
    input  logic              ce_live,
    output logic              arm_req,
    output logic              commit_req,
    output logic              commit_val,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_hit;
    logic unused_rsvd;

    assign wr_hit      = wr_en && (wr_addr == REG_ADDR);
    assign unused_rsvd = ^wr_data;

    always_comb begin
        arm_req    = wr_hit &&  wr_data[CE_POS];
        commit_req = wr_hit && !wr_data[CE_POS];
        commit_val = wr_data[SEL_POS];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_ADDR) begin
            rd_data[SEL_POS] = sel;
            rd_data[CE_POS]  = ce_live;
        end
    end

endmodule

// File: rtl/ivs_unlock_fsm.sv
`timescale 1ns/1ps
// Unlock sequencer: owns the select bit, the window counter and the sequence block.
module ivs_unlock_fsm
    import ivs_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic commit_req,
    input  logic commit_val,
    input  logic retire,
    output logic sel_o,
    output logic ce_live,
    output logic seq_block
);

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    ivs_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sel_q, sel_d;

    // Next-state logic: transitions ARM, COMMIT, EXPIRE, RELEASE
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        sel_d = sel_q;
        unique case (st_q)
            ST_IDLE: begin
                if (arm_req) begin                 // ARM
                    st_d  = ST_ARMED;
                    cnt_d = CNT_FULL;
                end
            end
            ST_ARMED: begin
                if (arm_req) begin                 // ARM (restart)
                    cnt_d = CNT_FULL;
                end else if (commit_req) begin     // COMMIT
                    st_d  = ST_HOLD;
                    sel_d = commit_val;
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin  // EXPIRE
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CNT_LAST;
                end
            end
            ST_HOLD: begin
                if (arm_req) begin                 // ARM
                    st_d  = ST_ARMED;
                    cnt_d = CNT_FULL;
                end else if (retire) begin         // RELEASE
                    st_d  = ST_IDLE;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sel_q <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        sel_o     = sel_q;
        ce_live   = (st_q == ST_ARMED);
        seq_block = (st_q == ST_ARMED) || (st_q == ST_HOLD);
    end

    // Assertions
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED) |-> (cnt_q >= CNT_LAST && cnt_q <= CNT_FULL));

    p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && cnt_q == CNT_LAST && !arm_req && !commit_req) |=> (st_q == ST_IDLE));

    p_sel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> $past(st_q == ST_ARMED && commit_req && !arm_req));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && arm_req) |=> (st_q == ST_ARMED && cnt_q == CNT_FULL && $stable(sel_q)));

    p_hold_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && retire && !arm_req) |=> (st_q == ST_IDLE));

    p_hold_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !retire && !arm_req) |=> (st_q == ST_HOLD));

endmodule

// File: rtl/ivs_lock_policy.sv
`timescale 1ns/1ps
// Lock policy: merges the sequence block with the section-dependent lock rules.
module ivs_lock_policy (
    input  logic sel,
    input  logic in_boot,
    input  logic lock_boot,
    input  logic lock_app,
    input  logic seq_block,
    output logic irq_block
);

    logic boot_rule;
    logic app_rule;

    always_comb begin
        boot_rule = sel  && lock_boot && !in_boot;
        app_rule  = !sel && lock_app  &&  in_boot;
        irq_block = seq_block || boot_rule || app_rule;
    end

endmodule

// File: rtl/ivs_vector_select.sv
`timescale 1ns/1ps
module ivs_vector_select #(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 6'h35,
    parameter int                WINDOW    = 4,
    parameter int                BASE_W    = 16,
    parameter logic [BASE_W-1:0] APP_BASE  = 16'h0000,
    parameter logic [BASE_W-1:0] BOOT_BASE = 16'h3800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              retire,
    input  logic              in_boot,
    input  logic              lock_boot,
    input  logic              lock_app,
    output logic [BASE_W-1:0] vec_base,
    output logic              irq_block
);

    localparam int CE_POS  = 0;
    localparam int SEL_POS = 1;

    logic arm_req, commit_req, commit_val;
    logic vsel, ce_live, seq_block;

    ivs_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
        .CE_POS(CE_POS), .SEL_POS(SEL_POS)
    ) u_regif (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .sel(vsel), .ce_live(ce_live),
        .arm_req(arm_req), .commit_req(commit_req), .commit_val(commit_val),
        .rd_data(rd_data)
    );

    ivs_unlock_fsm #(.WINDOW(WINDOW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .arm_req(arm_req), .commit_req(commit_req), .commit_val(commit_val),
        .retire(retire),
        .sel_o(vsel), .ce_live(ce_live), .seq_block(seq_block)
    );

    ivs_lock_policy u_policy (
        .sel(vsel), .in_boot(in_boot), .lock_boot(lock_boot), .lock_app(lock_app),
        .seq_block(seq_block), .irq_block(irq_block)
    );

    assign vec_base = vsel ? BOOT_BASE : APP_BASE;

    // Assertions
    p_boot_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_base == BOOT_BASE && lock_boot && !in_boot) |-> irq_block);

    p_app_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_base == APP_BASE && lock_app && in_boot) |-> irq_block);

    p_window_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_ADDR && rd_data[CE_POS]) |-> irq_block);

    p_base_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_base == APP_BASE) || (vec_base == BOOT_BASE));

endmodule

// File: tb/sim_ivs_vector_select.sv
`timescale 1ns/1ps
module sim_ivs_vector_select;

    localparam logic [5:0]  RA   = 6'h35;
    localparam logic [15:0] APPB = 16'h0000;
    localparam logic [15:0] BOOTB = 16'h3800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [5:0]  rd_addr = RA;
    logic [7:0]  rd_data;
    logic        retire = 1'b0;
    logic        in_boot = 1'b0;
    logic        lock_boot = 1'b0;
    logic        lock_app = 1'b0;
    logic [15:0] vec_base;
    logic        irq_block;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic exp_sel = 1'b0;

    always #2.5 clk = ~clk;

    ivs_vector_select u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .retire(retire), .in_boot(in_boot),
        .lock_boot(lock_boot), .lock_app(lock_app), .vec_base(vec_base), .irq_block(irq_block)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_retire();
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
    endtask

    function automatic logic [7:0] rd_exp(input logic s, input logic ce);
        return {6'b0, s, ce};
    endfunction

    task automatic set_sel(input logic s);
        wr(RA, 8'h01);
        wr(RA, {6'b0, s, 1'b0});
        pulse_retire();
        exp_sel = s;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 vec_base", vec_base, APPB);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq_block", irq_block, 0);

        // R10 other read address, write to other address ignored
        rd_addr = 6'h12; #1;
        chk("R10 rd other addr", rd_data, 0);
        rd_addr = RA;
        wr(6'h12, 8'h03);
        chk("R10 foreign write ce", rd_data, rd_exp(0, 0));
        chk("R10 foreign write irq", irq_block, 0);

        // R2 R3 R4 R5 R9: sweep commit delay and value
        for (int nv = 0; nv < 2; nv++) begin
            for (int k = 0; k < 6; k++) begin
                logic acc;
                acc = (k <= 3);
                wr(RA, {6'b0, ~exp_sel, 1'b1});       // arm with opposite select bit
                chk("R2 arm read", rd_data, rd_exp(exp_sel, 1));
                chk("R5 block on arm", irq_block, 1);
                for (int j = 1; j <= k; j++) begin
                    idle(1);
                    chk("R4 window live", rd_data[0], (j <= 3));
                    chk("R5 block in window", irq_block, (j <= 3));
                end
                wr(RA, {6'b0, nv[0], 1'b0});
                if (acc) exp_sel = nv[0];
                chk("R3 commit select", rd_data, rd_exp(exp_sel, 0));
                chk("R9 vec_base", vec_base, exp_sel ? BOOTB : APPB);
                chk("R5 block after commit", irq_block, acc);
                idle(2);
                chk("R5 hold until retire", irq_block, acc);
                pulse_retire();
                chk("R5 release", irq_block, 0);
            end
        end

        // R6 restart window
        set_sel(0);
        wr(RA, 8'h03);
        idle(3);
        wr(RA, 8'h03);                                 // restart at last window cycle
        chk("R6 select kept", vec_base, APPB);
        chk("R6 window open", rd_data, rd_exp(0, 1));
        idle(3);
        chk("R6 window still open", rd_data, rd_exp(0, 1));
        wr(RA, 8'h02);
        chk("R6 late commit taken", vec_base, BOOTB);
        pulse_retire();
        exp_sel = 1;

        // R4 commit with no window is ignored
        wr(RA, 8'h00);
        chk("R4 stray commit", vec_base, BOOTB);
        chk("R4 stray commit irq", irq_block, 0);

        // R7 R8 policy sweep
        for (int s = 0; s < 2; s++) begin
            set_sel(s[0]);
            for (int v = 0; v < 8; v++) begin
                logic e;
                lock_boot = v[0]; lock_app = v[1]; in_boot = v[2];
                #1;
                e = (s[0] && v[0] && !v[2]) || (!s[0] && v[1] && v[2]);
                if (s[0]) chk("R7 boot lock", irq_block, e);
                else      chk("R8 app lock", irq_block, e);
                idle(1);
            end
            lock_boot = 0; lock_app = 0; in_boot = 0;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule